// File: doc/BRIEF.md
# Four-Channel External Interrupt Edge/Level Detector

This block watches four asynchronous interrupt pins and turns each into a latched request for an interrupt controller. Every pin is first brought into the clock domain by a synchronizer. Each channel then looks for its own trigger condition: an edge of a chosen direction, or a level of a chosen sense. When the condition is seen, the channel's flag is set, and the flag drives that channel's request line directly.

Software reaches the block through a small word-wide register port. There are three registers: flags, mode and polarity. In each of them, bit n belongs to channel n. Flags are write-one-to-clear, and a handler is expected to clear its flag before it returns. In level mode, a pin that is still active makes the flag come back on the next cycle. In edge mode, an edge that lands in the same cycle as the clear is not lost.

Top module: `ext_irq_detect`

## Requirements
- R1: After synchronous reset all flags, all mode bits and all polarity bits read 0 (every channel level-sensitive, active-low), and every request line is low.
- R2: Register select on reg_addr: 0 = flags, 1 = mode, 2 = polarity, 3 = reserved. Bit n of each register is channel n. Reads return the selected register combinationally, and the reserved address reads 0. A write to address 3 changes neither mode nor polarity.
- R3: A pin change applied between clock edges is seen at the flag after the third rising clock edge, and not after the second (two synchronizer flops, then the flag).
- R4: With mode bit 1 (edge), polarity 1 sets the flag on a low-to-high transition of the synchronized pin and polarity 0 on a high-to-low transition. A transition in the other direction, or a steady pin, sets nothing.
- R5: With mode bit 0 (level), the flag is set whenever the synchronized pin equals the polarity bit (1 = active-high, 0 = active-low).
- R6: Writing 1 to a flag bit clears it. Writing 0 to a flag bit leaves it unchanged.
- R7: In level mode, a clear takes effect for one cycle. If the pin is still active, the flag reads 1 again one cycle later.
- R8: In edge mode, an edge whose flag update falls in the same cycle as a clear of that flag leaves the flag set.
- R9: Rewriting mode or polarity while a pin is steady never creates an edge event, so no flag is set by the change itself.
- R10: Request line n always equals flag bit n.
- R11: Channels are independent: a condition on one channel sets only that channel's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_CH | Asynchronous interrupt pins, one per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 flags, 1 mode, 2 polarity, 3 reserved) |
| reg_wdata | input | NUM_CH | Write data, bit n for channel n |
| reg_rdata | output | NUM_CH | Read data of the selected register |
| irq_o | output | NUM_CH | Interrupt request lines to the controller |

## Verification
The bench builds the block with its default parameters: four channels, two synchronizer stages and an idle-high reset value for the pins. With two stages the trigger-to-flag delay is exactly three edges, so the bench can check both sides of that boundary and can line up a clear write with the very cycle an edge lands. Four channels let the vector table place each mode and polarity combination on a different channel and compare the whole flag register, which shows that no neighbour is disturbed.

// File: rtl/eid_pkg.sv
package eid_pkg;

    typedef enum logic [1:0] {
        SEL_FLAG = 2'd0,
        SEL_MODE = 2'd1,
        SEL_POL  = 2'd2,
        SEL_RSV  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic edge_mode;   // 1 = edge, 0 = level
        logic act_high;    // 1 = rising / high, 0 = falling / low
    } chan_cfg_t;

    function automatic logic edge_event(chan_cfg_t c, logic cur, logic prev);
        return c.act_high ? (cur & ~prev) : (~cur & prev);
    endfunction

    function automatic logic level_event(chan_cfg_t c, logic cur);
        return cur == c.act_high;
    endfunction

endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
    parameter int   WIDTH  = 4,
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam logic [WIDTH-1:0] IDLE_VEC = {WIDTH{IDLE}};

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= {STAGES{IDLE_VEC}};
        end else begin
            stg_q <= {stg_q[STAGES-2:0], din};
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/eid_regs.sv
module eid_regs
    import eid_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [1:0]                  addr,
    input  logic [NUM_CH-1:0]           wdata,
    input  logic [NUM_CH-1:0]           flags,
    output logic [NUM_CH-1:0]           rdata,
    output chan_cfg_t [NUM_CH-1:0]      cfg,
    output logic [NUM_CH-1:0]           clr
);
    logic [NUM_CH-1:0] mode_q;
    logic [NUM_CH-1:0] pol_q;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            pol_q  <= '0;
        end else if (we) begin
            if (sel == SEL_MODE) mode_q <= wdata;
            if (sel == SEL_POL)  pol_q  <= wdata;
        end
    end

    assign clr = (we && sel == SEL_FLAG) ? wdata : '0;

    always_comb begin
        case (sel)
            SEL_FLAG: rdata = flags;
            SEL_MODE: rdata = mode_q;
            SEL_POL:  rdata = pol_q;
            default:  rdata = '0;
        endcase
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cfg
        assign cfg[ch].edge_mode = mode_q[ch];
        assign cfg[ch].act_high  = pol_q[ch];
    end

    AST_RSV_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 2'd3) |=> ($stable(mode_q) && $stable(pol_q))); // R2

endmodule

// File: rtl/eid_channel.sv
module eid_channel
    import eid_pkg::*;
#(
    parameter logic IDLE = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg_i,
    input  logic      sync_i,
    input  logic      clr_i,
    output logic      flag_o
);
    logic prev_q;
    logic flag_q;
    logic hit;

    assign hit = cfg_i.edge_mode ? edge_event(cfg_i, sync_i, prev_q)
                                 : level_event(cfg_i, sync_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= IDLE;
            flag_q <= 1'b0;
        end else begin
            prev_q <= sync_i;
            if (cfg_i.edge_mode) begin
                // a fresh edge outranks a clear
                flag_q <= hit | (flag_q & ~clr_i);
            end else begin
                // clear outranks the level; level re-sets next cycle
                flag_q <= ~clr_i & (hit | flag_q);
            end
        end
    end

    assign flag_o = flag_q;

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.edge_mode && (cfg_i.act_high ? (sync_i && !prev_q) : (!sync_i && prev_q)))
        |=> flag_q); // R4

    AST_EDGE_CLEAR_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.edge_mode && clr_i && sync_i != prev_q && sync_i == cfg_i.act_high)
        |=> flag_q); // R8

    AST_NO_EDGE_STEADY: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.edge_mode && sync_i == prev_q && !flag_q) |=> !flag_q); // R9

    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (rst)
        (!cfg_i.edge_mode && sync_i == cfg_i.act_high && !clr_i) |=> flag_q); // R5

    AST_LEVEL_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (!cfg_i.edge_mode && clr_i) |=> !flag_q); // R7

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i) |=> flag_q); // R6

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import eid_pkg::*;
#(
    parameter int   NUM_CH      = 4,
    parameter int   SYNC_STAGES = 2,
    parameter logic PIN_IDLE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [NUM_CH-1:0] reg_wdata,
    output logic [NUM_CH-1:0] reg_rdata,
    output logic [NUM_CH-1:0] irq_o
);
    logic [NUM_CH-1:0]      pin_sync;
    logic [NUM_CH-1:0]      flag;
    logic [NUM_CH-1:0]      clr;
    chan_cfg_t [NUM_CH-1:0] cfg;

    eid_sync #(
        .WIDTH  (NUM_CH),
        .STAGES (SYNC_STAGES),
        .IDLE   (PIN_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_i),
        .dout (pin_sync)
    );

    eid_regs #(
        .NUM_CH (NUM_CH)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .flags (flag),
        .rdata (reg_rdata),
        .cfg   (cfg),
        .clr   (clr)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        eid_channel #(
            .IDLE (PIN_IDLE)
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .cfg_i  (cfg[ch]),
            .sync_i (pin_sync[ch]),
            .clr_i  (clr[ch]),
            .flag_o (flag[ch])
        );
    end

    assign irq_o = flag;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (irq_o == '0)); // R1

endmodule

// File: tb/ext_irq_detect_test.sv
module ext_irq_detect_test;

    localparam logic [1:0] A_FLAG = 2'd0;
    localparam logic [1:0] A_MODE = 2'd1;
    localparam logic [1:0] A_POL  = 2'd2;
    localparam logic [1:0] A_RSV  = 2'd3;

    // {channel[1:0], mode, polarity, start level, end level}
    localparam int NVEC = 8;
    localparam logic [5:0] VEC [NVEC] = '{
        6'b001010, 6'b011110, 6'b101101, 6'b111000,
        6'b000101, 6'b010011, 6'b100001, 6'b110110
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pin = 4'hF;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [3:0] wdata = 4'h0;
    logic [3:0] rdata;
    logic [3:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ext_irq_detect uut (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (pin),
        .reg_we    (we),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_o     (irq)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; addr = A_FLAG; wdata = 4'h0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] d);
        addr = a;
        #1;
        d = rdata;
        addr = A_FLAG;
    endtask

    function automatic logic expect_flag(logic m, logic p, logic s, logic e);
        if (m) return (s != e) && (e == p);
        return (s == p) || (e == p);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] v;
        idle(3);
        rst = 1'b0;

        // R1 reset state
        rd(A_FLAG, v); chk("R1 flags after reset", v, 4'h0);
        rd(A_MODE, v); chk("R1 mode after reset", v, 4'h0);
        rd(A_POL, v);  chk("R1 polarity after reset", v, 4'h0);
        chk("R1 irq after reset", irq, 4'h0);
        idle(5);
        rd(A_FLAG, v); chk("R1 idle-high pins stay quiet", v, 4'h0);

        // table: R4 R5 R11 R10 R2
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] ch;
            logic m, p, s, e;
            logic [3:0] onehot;
            {ch, m, p, s, e} = VEC[i];
            onehot = 4'b0001 << ch;
            pin[ch] = s;
            wr(A_MODE, m ? onehot : 4'h0);
            wr(A_POL,  p ? onehot : 4'h0);
            rd(A_MODE, v); chk("R2 mode readback", v, m ? onehot : 4'h0);
            idle(4);
            wr(A_FLAG, 4'hF);
            pin[ch] = e;
            idle(5);
            rd(A_FLAG, v);
            chk(m ? "R4 R11 edge vector" : "R5 R11 level vector", v,
                expect_flag(m, p, s, e) ? onehot : 4'h0);
            chk("R10 irq equals flags", irq, v);
            pin[ch] = 1'b1;
            idle(3);
            wr(A_MODE, 4'h0);
            wr(A_POL, 4'h0);
            idle(4);
            wr(A_FLAG, 4'hF);
            idle(1);
            rd(A_FLAG, v); chk("R6 restore clear", v, 4'h0);
        end

        // R3 latency, channel 0 edge falling
        wr(A_MODE, 4'b0001);
        idle(4);
        wr(A_FLAG, 4'hF);
        rd(A_FLAG, v); chk("R3 cleared before pin change", v, 4'h0);
        pin[0] = 1'b0;
        idle(2);
        rd(A_FLAG, v); chk("R3 not yet after two edges", v, 4'h0);
        idle(1);
        rd(A_FLAG, v); chk("R3 set after third edge", v, 4'b0001);
        chk("R10 irq follows flag", irq, 4'b0001);

        // R6 write-one-to-clear
        wr(A_FLAG, 4'b1110);
        rd(A_FLAG, v); chk("R6 zero bit leaves flag", v, 4'b0001);
        wr(A_FLAG, 4'b0000);
        rd(A_FLAG, v); chk("R6 all-zero write no effect", v, 4'b0001);
        wr(A_FLAG, 4'b0001);
        rd(A_FLAG, v); chk("R6 one clears", v, 4'h0);

        // R4 opposite edge ignored
        pin[0] = 1'b1;
        idle(5);
        rd(A_FLAG, v); chk("R4 rising ignored in falling mode", v, 4'h0);

        // R7 level clear then re-assert, channel 2 active-high, pin high
        wr(A_POL, 4'b0100);
        idle(4);
        rd(A_FLAG, v); chk("R5 active-high level sets", v, 4'b0100);
        wr(A_FLAG, 4'b0100);
        rd(A_FLAG, v); chk("R7 clear visible one cycle", v, 4'h0);
        idle(1);
        rd(A_FLAG, v); chk("R7 re-asserts next cycle", v, 4'b0100);
        pin[2] = 1'b0;
        idle(4);
        wr(A_FLAG, 4'b0100);
        idle(2);
        rd(A_FLAG, v); chk("R7 stays clear once inactive", v, 4'h0);
        pin[2] = 1'b1;
        wr(A_POL, 4'b0000);
        idle(4);
        wr(A_FLAG, 4'hF);

        // R8 edge lands in same cycle as clear, channel 3 rising
        pin[3] = 1'b0;
        wr(A_MODE, 4'b1000);
        wr(A_POL, 4'b1000);
        idle(4);
        wr(A_FLAG, 4'hF);
        rd(A_FLAG, v); chk("R8 start clear", v, 4'h0);
        pin[3] = 1'b1;
        idle(2);
        wr(A_FLAG, 4'b1000);
        rd(A_FLAG, v); chk("R8 edge beats clear", v, 4'b1000);
        wr(A_FLAG, 4'b1000);
        rd(A_FLAG, v); chk("R8 later clear works", v, 4'h0);

        // R9 configuration change on steady pin
        wr(A_POL, 4'b0000);
        idle(4);
        rd(A_FLAG, v); chk("R9 polarity flip no flag", v, 4'h0);
        wr(A_POL, 4'b1000);
        idle(4);
        rd(A_FLAG, v); chk("R9 polarity flip back no flag", v, 4'h0);
        wr(A_POL, 4'b0000);
        wr(A_MODE, 4'b0000);
        idle(4);
        rd(A_FLAG, v); chk("R9 mode change no flag", v, 4'h0);

        // R2 reserved address
        wr(A_MODE, 4'b0101);
        wr(A_POL, 4'b0100);
        wr(A_RSV, 4'hF);
        rd(A_MODE, v); chk("R2 mode kept after reserved write", v, 4'b0101);
        rd(A_POL, v);  chk("R2 polarity kept after reserved write", v, 4'b0100);
        rd(A_RSV, v);  chk("R2 reserved reads zero", v, 4'h0);
        idle(4);
        rd(A_FLAG, v); chk("R11 no stray flags", v, 4'h0);
        chk("R10 irq quiet", irq, 4'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule